// File: doc/BRIEF.md
# Gated 13-bit Counter/Timer

A single counter/timer channel holding a 13-bit count made of a 5-bit low field and an 8-bit high field. Each field can be loaded on its own through a simple write port. The count advances on a selected source. The first option is every system clock cycle. The second is a prescaled tick from a free-running divider, at one of three ratios. The third is a synchronized falling edge on an external count pin. When the count rolls over from all ones, a sticky overflow flag is raised. This flag is intended to drive an interrupt request elsewhere.

Counting is allowed by a run bit. In gate mode, counting also needs an external gate input to be at its active level, and an inversion bit chooses that level. With the system clock as the source, the count then measures the width of a gate pulse directly in cycles. Starting the run does not reset the count, so software loads a start value first.

Top module: `gtimer13`

## Requirements
- R1: After synchronous reset, `count` is 0 and `ovf` is 0.
- R2: While `run_en` is 0 and no field is written, `count` does not change, whatever the selected source does.
- R3: With `ext_mode`=0 and `sys_sel`=1, `count` advances by exactly one per cycle while counting is enabled.
- R4: With `ext_mode`=0 and `sys_sel`=0, the `scale` field picks a prescaled tick: 2'b00 gives one increment per 12 cycles, 2'b01 one per 4, and 2'b10 one per 48. The tick is free-running, so any window of k·N enabled cycles advances the count by exactly k.
- R5: With `ext_mode`=0, `sys_sel`=0 and `scale`=2'b11, each synchronized falling edge of `ext_pin` advances the count by one.
- R6: With `ext_mode`=1, each high-to-low transition of `ext_pin` advances the count by exactly one, regardless of `sys_sel`. Rising edges and steady levels add nothing.
- R7: With `gate_mode`=1, counting takes place only while `gate_in` XOR `gate_inv` is 1, so `gate_inv`=0 makes the gate active high. The gate passes through a synchronizer of fixed depth, which means an active pulse of n cycles admits exactly n system-clock counts. With `gate_mode`=0, `gate_in` has no effect.
- R8: `lo_wr` loads `lo_wdata` into count bits 4:0, and `hi_wr` loads `hi_wdata` into count bits 12:5. The field that is not written keeps its value. A write cycle performs no increment.
- R9: Setting `run_en` does not clear the count; counting resumes from the held value.
- R10: An increment at count 8191 wraps the count to 0 and sets `ovf` on the same edge.
- R11: `ovf` stays at 1 until a cycle with `ovf_clr`=1. If a wrap and a clear fall in the same cycle, the wrap wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run bit |
| gate_mode | input | 1 | Require the gate input to be active |
| gate_inv | input | 1 | Gate polarity: 0 active high, 1 active low |
| gate_in | input | 1 | External gate input (asynchronous) |
| ext_mode | input | 1 | 1: count falling edges of ext_pin |
| sys_sel | input | 1 | With ext_mode=0: 1 system clock, 0 prescaled tick |
| scale | input | 2 | Prescaler select |
| ext_pin | input | 1 | External count pin (asynchronous) |
| lo_wr | input | 1 | Write strobe, low field |
| lo_wdata | input | 5 | Low field write data |
| hi_wr | input | 1 | Write strobe, high field |
| hi_wdata | input | 8 | High field write data |
| ovf_clr | input | 1 | Clear the overflow flag |
| count | output | 13 | Current count |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The hardest situation to reach from the ports is a wrap that coincides with a flag clear. The count must sit at exactly 8191 with an enable active for a single edge while `ovf_clr` is high. The stimulus reaches it by loading both fields in one write cycle and then opening the run bit, on the system clock source, for exactly one edge while the clear is held high. Gate-pulse widths are checked by counting system-clock increments over a gate pulse of known length, in each polarity. Prescaler ratios are checked over windows that are whole multiples of the divisor, so the result does not depend on the divider's phase.

// File: rtl/gtimer13.sv
module gtimer13 #(
  parameter int LO_W  = 5,
  parameter int HI_W  = 8,
  parameter int DIV_A = 12,
  parameter int DIV_B = 4,
  parameter int DIV_C = 48,
  parameter int SYNC  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run_en,
  input  logic                 gate_mode,
  input  logic                 gate_inv,
  input  logic                 gate_in,
  input  logic                 ext_mode,
  input  logic                 sys_sel,
  input  logic [1:0]           scale,
  input  logic                 ext_pin,
  input  logic                 lo_wr,
  input  logic [LO_W-1:0]      lo_wdata,
  input  logic                 hi_wr,
  input  logic [HI_W-1:0]      hi_wdata,
  input  logic                 ovf_clr,
  output logic [LO_W+HI_W-1:0] count,
  output logic                 ovf
);
  localparam int CW   = LO_W + HI_W;
  localparam int DMAX = (DIV_A > DIV_B) ? ((DIV_A > DIV_C) ? DIV_A : DIV_C)
                                        : ((DIV_B > DIV_C) ? DIV_B : DIV_C);
  localparam int PW   = $clog2(DMAX + 1);

  logic [SYNC-1:0] pin_s, gate_s;
  logic            pin_prev;
  logic [2:0]      pre_tick;
  logic            pin_fall, gate_ok, src_tick, inc_en, wr_any, wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_s    <= '0;
      gate_s   <= '0;
      pin_prev <= 1'b0;
    end else begin
      pin_s    <= {pin_s[SYNC-2:0], ext_pin};
      gate_s   <= {gate_s[SYNC-2:0], gate_in};
      pin_prev <= pin_s[SYNC-1];
    end
  end

  assign pin_fall = pin_prev & ~pin_s[SYNC-1];

  for (genvar i = 0; i < 3; i++) begin : g_pre
    localparam int D = (i == 0) ? DIV_A : (i == 1) ? DIV_B : DIV_C;
    logic [PW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)                    cnt <= '0;
      else if (cnt == PW'(D - 1)) cnt <= '0;
      else                        cnt <= cnt + 1'b1;
    end
    assign pre_tick[i] = (cnt == PW'(D - 1));
  end

  always_comb begin
    if (ext_mode)     src_tick = pin_fall;
    else if (sys_sel) src_tick = 1'b1;
    else begin
      case (scale)
        2'b00:   src_tick = pre_tick[0];
        2'b01:   src_tick = pre_tick[1];
        2'b10:   src_tick = pre_tick[2];
        default: src_tick = pin_fall;
      endcase
    end
  end

  assign gate_ok = ~gate_mode | (gate_s[SYNC-1] ^ gate_inv);
  assign inc_en  = run_en & gate_ok & src_tick;
  assign wr_any  = lo_wr | hi_wr;
  assign wrap    = inc_en & ~wr_any & (&count);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (wr_any) begin
        if (lo_wr) count[LO_W-1:0]  <= lo_wdata;
        if (hi_wr) count[CW-1:LO_W] <= hi_wdata;
      end else if (inc_en) begin
        count <= count + 1'b1;
      end
      if (wrap)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/gtimer13_chk.sv
module gtimer13_chk #(
  parameter int LO_W = 5,
  parameter int HI_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 run_en,
  input logic                 lo_wr,
  input logic [LO_W-1:0]      lo_wdata,
  input logic                 hi_wr,
  input logic [HI_W-1:0]      hi_wdata,
  input logic                 ovf_clr,
  input logic                 inc_en,
  input logic [LO_W+HI_W-1:0] count,
  input logic                 ovf
);
  localparam int CW = LO_W + HI_W;

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !lo_wr && !hi_wr) |=> (count == $past(count)));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!lo_wr && !hi_wr) |=> (count == $past(count) || count == $past(count) + CW'(1)));

  p_lo_load_r8: assert property (@(posedge clk) disable iff (rst)
    lo_wr |=> (count[LO_W-1:0] == $past(lo_wdata)));

  p_hi_load_r8: assert property (@(posedge clk) disable iff (rst)
    hi_wr |=> (count[CW-1:LO_W] == $past(hi_wdata)));

  p_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (inc_en && (&count) && !lo_wr && !hi_wr) |=> (count == '0 && ovf));

  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);

  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !(inc_en && (&count) && !lo_wr && !hi_wr)) |=> !ovf);
endmodule

bind gtimer13 gtimer13_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .lo_wr(lo_wr), .lo_wdata(lo_wdata),
  .hi_wr(hi_wr), .hi_wdata(hi_wdata), .ovf_clr(ovf_clr), .inc_en(inc_en),
  .count(count), .ovf(ovf)
);

// File: tb/sim_gtimer13.sv
module sim_gtimer13;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 0, gate_mode = 0, gate_inv = 0, gate_in = 0;
  logic        ext_mode = 0, sys_sel = 1, ext_pin = 1;
  logic [1:0]  scale = 2'b00;
  logic        lo_wr = 0, hi_wr = 0, ovf_clr = 0;
  logic [4:0]  lo_wdata = '0;
  logic [7:0]  hi_wdata = '0;
  logic [12:0] count;
  logic        ovf;

  typedef struct {
    string       req;
    logic [12:0] cnt;
    logic        flag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0, cycles = 0;
  bit   done = 0;
  logic [12:0] mdl = '0;

  always #2 clk = ~clk;

  gtimer13 u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .gate_mode(gate_mode), .gate_inv(gate_inv),
    .gate_in(gate_in), .ext_mode(ext_mode), .sys_sel(sys_sel), .scale(scale),
    .ext_pin(ext_pin), .lo_wr(lo_wr), .lo_wdata(lo_wdata), .hi_wr(hi_wr),
    .hi_wdata(hi_wdata), .ovf_clr(ovf_clr), .count(count), .ovf(ovf)
  );

  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (count !== e.cnt || ovf !== e.flag) begin
        n_fail++;
        $display("FAIL %s: count=%0d ovf=%0b expected count=%0d ovf=%0b",
                 e.req, count, ovf, e.cnt, e.flag);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(string req, logic [12:0] c, logic f);
    exp_t e;
    e.req = req; e.cnt = c; e.flag = f;
    q.push_back(e);
    idle(2);
  endtask

  task automatic run_for(int n);
    run_en = 1;
    idle(n);
    run_en = 0;
    idle(4);
  endtask

  task automatic pin_pulses(int n);
    for (int i = 0; i < n; i++) begin
      ext_pin = 0; idle(4);
      ext_pin = 1; idle(4);
    end
    idle(4);
  endtask

  task automatic write_fields(bit wl, logic [4:0] l, bit wh, logic [7:0] h);
    lo_wr = wl; lo_wdata = l; hi_wr = wh; hi_wdata = h;
    idle(1);
    lo_wr = 0; hi_wr = 0;
    idle(2);
  endtask

  initial begin
    idle(4);
    rst = 0;
    idle(1);
    expect_now("R1 reset", 13'd0, 1'b0);

    idle(10);
    expect_now("R2 idle hold", 13'd0, 1'b0);

    run_for(25); mdl = 25;
    expect_now("R3 system clock", mdl, 1'b0);

    run_for(5); mdl += 5;
    expect_now("R9 resume no clear", mdl, 1'b0);

    write_fields(1, 5'd10, 0, 8'd0); mdl = {mdl[12:5], 5'd10};
    expect_now("R8 low write", mdl, 1'b0);
    write_fields(0, 5'd0, 1, 8'd3); mdl = {8'd3, mdl[4:0]};
    expect_now("R8 high write", mdl, 1'b0);

    run_en = 1; lo_wr = 1; lo_wdata = 5'd5;
    idle(1);
    run_en = 0; lo_wr = 0;
    idle(2);
    mdl = {mdl[12:5], 5'd5};
    expect_now("R8 write beats increment", mdl, 1'b0);

    sys_sel = 0;
    scale = 2'b00; run_for(48); mdl += 4;
    expect_now("R4 divide 12", mdl, 1'b0);
    scale = 2'b01; run_for(48); mdl += 12;
    expect_now("R4 divide 4", mdl, 1'b0);
    scale = 2'b10; run_for(96); mdl += 2;
    expect_now("R4 divide 48", mdl, 1'b0);

    scale = 2'b11;
    run_en = 1; pin_pulses(3); run_en = 0; idle(2); mdl += 3;
    expect_now("R5 scaled pin tick", mdl, 1'b0);
    pin_pulses(3);
    expect_now("R2 pin edges while stopped", mdl, 1'b0);

    ext_mode = 1; sys_sel = 1;
    run_en = 1; pin_pulses(5);
    ext_pin = 0; idle(20); ext_pin = 1; idle(20);
    run_en = 0; idle(2); mdl += 6;
    expect_now("R6 external falling edges", mdl, 1'b0);
    ext_mode = 0;

    gate_mode = 1; gate_inv = 0; gate_in = 0; idle(4);
    run_en = 1; idle(10);
    gate_in = 1; idle(7); gate_in = 0; idle(6);
    run_en = 0; idle(2); mdl += 7;
    expect_now("R7 gate active high pulse", mdl, 1'b0);

    gate_inv = 1; gate_in = 1; idle(4);
    run_en = 1; idle(5);
    gate_in = 0; idle(9); gate_in = 1; idle(6);
    run_en = 0; idle(2); mdl += 9;
    expect_now("R7 gate active low pulse", mdl, 1'b0);

    gate_mode = 0;
    run_for(6); mdl += 6;
    expect_now("R7 gate ignored when off", mdl, 1'b0);

    write_fields(1, 5'h1F, 1, 8'hFF);
    expect_now("R8 full load", 13'd8191, 1'b0);
    run_en = 1; idle(1); run_en = 0; idle(2);
    expect_now("R10 wrap", 13'd0, 1'b1);
    run_for(3);
    expect_now("R11 sticky", 13'd3, 1'b1);
    ovf_clr = 1; idle(1); ovf_clr = 0; idle(2);
    expect_now("R11 clear", 13'd3, 1'b0);

    write_fields(1, 5'h1F, 1, 8'hFF);
    run_en = 1; ovf_clr = 1; idle(1); run_en = 0; ovf_clr = 0; idle(2);
    expect_now("R11 wrap beats clear", 13'd0, 1'b1);
    ovf_clr = 1; idle(1); ovf_clr = 0; idle(2);
    expect_now("R11 clear after", 13'd0, 1'b0);

    idle(4);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule